// File: doc/BRIEF.md
# Pulse-Swallowing Divider Phase Aligner

Two multiplexed converters each divide a shared fast clock by four with a 2-bit counter. Each counter can come up in any of its four states, so the two latch clocks can be skewed by a whole number of fast-clock cycles. This block models both dividers and gates the fast clock of the first one. It compares the two divided clocks with an XOR detector. It then deletes single fast-clock pulses from the first path until both divided clocks match. The dividers are never reset to force alignment; alignment comes only from removing pulses.

The clock gate is modelled as a synchronous clock enable. `tick_a` and `tick_b` are the gate levels seen by the two divider paths. A rising fast-clock edge at which `tick_a` is low does not advance divider A. Path B has an always-open matching gate. The retiming stage that drives the gate updates on the falling edge of the fast clock, so the gate never changes while the clock is high. The start states of both dividers are model inputs, loaded while reset is held. The `locked` output reports a run of matching divided-clock periods.

Top module: `divphase_aligner`

## Requirements
- R1: While `rst_n` is low at a rising edge, divider A loads `init_a` and divider B loads `init_b`. During reset `tick_a`=1, `tick_b`=1 and `locked`=0. The divided clock of each path is the most significant bit of its counter.
- R2: Divider B advances by one at every rising fast-clock edge, and `tick_b` is always 1. So `dclk_b` is the fast clock divided by four, with a 50 % duty cycle.
- R3: Divider A advances at a rising edge only when `tick_a` is 1 at that edge. While `enable` is 1, a new mismatch between `dclk_a` and `dclk_b` causes `tick_a` to go low. A mismatch that has persisted since the previous correction does the same once that correction's wait has expired.
- R4: Each correction holds `tick_a` low for exactly one fast-clock cycle, so it removes exactly one pulse.
- R5: Two removed pulses are at least four fast-clock edges apart.
- R6: Let the start offset be o = (`init_b` − `init_a`) mod 4. The block removes exactly (4 − o) mod 4 pulses in total. After that, `dclk_a` equals `dclk_b` permanently.
- R7: While `enable` is 0, no pulse is removed and `locked` is 0 in the following cycle. When `enable` rises with a mismatch present, correction starts.
- R8: `locked` is 1 in a cycle exactly when each of the preceding 32 fast-clock cycles (8 divided periods) had `enable`=1 and `dclk_a` = `dclk_b`. A single mismatching cycle clears it in the next cycle.
- R9: `tick_a` changes only on falling edges of the fast clock, never across a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows pulse removal and lock counting |
| init_a | input | 2 | Start state of divider A, loaded in reset |
| init_b | input | 2 | Start state of divider B, loaded in reset |
| tick_a | output | 1 | Clock gate level of path A (0 removes the next pulse) |
| tick_b | output | 1 | Matching gate level of path B, always open |
| dclk_a | output | 1 | Divided clock of path A |
| dclk_b | output | 1 | Divided clock of path B |
| locked | output | 1 | Divided clocks have matched for 8 periods |

## Verification
Two functions can fall in the same cycle: a fresh rising edge of the XOR detector, and the wait that follows a previous correction. At offsets of one and three the mismatch toggles every other cycle, so edges keep arriving while the wait is still running. The bench provokes this through random and directed start offsets. It judges the result by the exact total of removed pulses, the spacing between them, and the cycle at which `locked` rises, all compared with values computed from the offset. Offset two is also covered: there the detector output stays high with no further edge, so the block must re-trigger on the persisting mismatch.

// File: rtl/divphase_aligner.sv
module divphase_aligner #(
  parameter int DIV_W        = 2,
  parameter int LOCK_PERIODS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] init_a,
  input  logic [DIV_W-1:0] init_b,
  output logic             tick_a,
  output logic             tick_b,
  output logic             dclk_a,
  output logic             dclk_b,
  output logic             locked
);

  localparam int PERIOD   = 1 << DIV_W;
  localparam int LOCK_CYC = LOCK_PERIODS * PERIOD;
  localparam int QW       = $clog2(LOCK_CYC + 1);

  logic [DIV_W-1:0] div_a, div_b, wait_cnt;
  logic [QW-1:0]    quiet;
  logic             mism, mism_q, held, fire, swl_q;

  assign dclk_a = div_a[DIV_W-1];
  assign dclk_b = div_b[DIV_W-1];
  assign mism   = dclk_a ^ dclk_b;
  assign fire   = enable && mism && (wait_cnt == '0) && (!mism_q || held);
  assign tick_a = ~swl_q;
  assign tick_b = 1'b1;
  assign locked = (quiet == QW'(LOCK_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_a    <= init_a;
      div_b    <= init_b;
      mism_q   <= 1'b0;
      held     <= 1'b0;
      wait_cnt <= '0;
      quiet    <= '0;
    end else begin
      div_b  <= div_b + 1'b1;
      if (tick_a) div_a <= div_a + 1'b1;
      mism_q <= enable & mism;
      if (fire)      held <= 1'b1;
      else if (!mism) held <= 1'b0;
      if (fire)                 wait_cnt <= DIV_W'(PERIOD - 1);
      else if (wait_cnt != '0)  wait_cnt <= wait_cnt - 1'b1;
      if (!enable || mism) quiet <= '0;
      else if (!locked)    quiet <= quiet + 1'b1;
    end
  end

  always_ff @(negedge clk) begin
    if (!rst_n) swl_q <= 1'b0;
    else        swl_q <= fire;
  end

  logic [DIV_W:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n)                         gap <= (DIV_W+1)'(PERIOD);
    else if (swl_q)                     gap <= (DIV_W+1)'(1);
    else if (gap < (DIV_W+1)'(PERIOD))  gap <= gap + 1'b1;
  end

  a_r2_b_runs: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> div_b == DIV_W'($past(div_b) + 1'b1));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(swl_q)) |-> div_a == $past(div_a));
  a_r3_cause: assert property (@(posedge clk) disable iff (!rst_n)
    swl_q |-> (mism && enable));
  a_r4_single: assert property (@(posedge clk) disable iff (!rst_n)
    swl_q |=> !swl_q);
  a_r5_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    swl_q |-> gap >= (DIV_W+1)'(PERIOD));
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !swl_q);
  a_r7_nolock: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(enable)) |-> !locked);
  a_r8_match: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && locked) |-> $past(dclk_a == dclk_b));

endmodule

// File: tb/divphase_aligner_tb.sv
module divphase_aligner_tb;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [1:0] init_a = '0, init_b = '0;
  logic tick_a, tick_b, dclk_a, dclk_b, locked;

  int checks = 0, failures = 0;
  bit done = 0;
  int run, nsw, cyc, last_sw;
  bit prev_low;
  logic [1:0] ea, eb;

  always #10 clk = ~clk;

  divphase_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .init_a(init_a), .init_b(init_b),
    .tick_a(tick_a), .tick_b(tick_b), .dclk_a(dclk_a), .dclk_b(dclk_b), .locked(locked)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] a, input logic [1:0] b, input logic en);
    @(posedge clk); #2;
    rst_n = 1'b0; init_a = a; init_b = b; enable = en;
    @(posedge clk); @(posedge clk); #14;
    chk(dclk_a == a[1], "R1 dclk_a in reset", dclk_a, a[1]);
    chk(dclk_b == b[1], "R1 dclk_b in reset", dclk_b, b[1]);
    chk(tick_a == 1'b1, "R1 tick_a in reset", tick_a, 1);
    chk(locked == 1'b0, "R1 locked in reset", locked, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    ea = a; eb = b; run = 0; nsw = 0; cyc = 0; last_sw = -100; prev_low = 0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      logic pre;
      #14;
      chk(locked == (run >= 32), "R8 locked window", locked, int'(run >= 32));
      chk(dclk_b == eb[1], "R2 divider B", dclk_b, eb[1]);
      chk(dclk_a == ea[1], "R3 divider A", dclk_a, ea[1]);
      chk(tick_b == 1'b1, "R2 tick_b open", tick_b, 1);
      pre = tick_a;
      if (!tick_a) begin
        nsw++;
        chk(!prev_low, "R4 single-cycle gate", 2, 1);
        chk(cyc - last_sw >= 4, "R5 spacing", cyc - last_sw, 4);
        chk(enable == 1'b1, "R7 swallow while disabled", enable, 1);
        last_sw = cyc;
      end
      prev_low = !tick_a;
      run = (enable && dclk_a == dclk_b) ? run + 1 : 0;
      eb = eb + 2'd1;
      if (tick_a) ea = ea + 2'd1;
      cyc++;
      @(posedge clk); #2;
      chk(tick_a == pre, "R9 tick_a stable over rising edge", tick_a, pre);
    end
  endtask

  task automatic trial(input logic [1:0] a, input logic [1:0] b, input int idle, input int active);
    int expn;
    expn = (4 - ((int'(b) - int'(a)) & 3)) & 3;
    do_reset(a, b, idle == 0);
    if (idle > 0) begin
      step(idle);
      chk(nsw == 0, "R7 no swallow while disabled", nsw, 0);
      chk(locked == 1'b0, "R7 no lock while disabled", locked, 0);
      enable = 1'b1;
    end
    step(active);
    chk(nsw == expn, "R6 swallow count", nsw, expn);
    chk(dclk_a == dclk_b, "R6 aligned", dclk_a, dclk_b);
    chk(locked == 1'b1, "R8 locked at end", locked, 1);
  endtask

  initial begin
    void'($urandom(32'd41577));
    for (int o = 0; o < 4; o++) trial(2'd0, 2'(o), 0, 100);
    for (int o = 1; o < 4; o++) trial(2'(o), 2'd3, 20, 100);
    trial(2'd2, 2'd3, 0, 80);
    enable = 1'b0;
    step(3);
    chk(locked == 1'b0, "R7 lock drops after disable", locked, 0);
    enable = 1'b1;
    step(40);
    chk(locked == 1'b1, "R8 relock", locked, 1);
    for (int t = 0; t < 30; t++) begin
      logic [1:0] ra, rb;
      int idl;
      ra = 2'($urandom_range(0, 3));
      rb = 2'($urandom_range(0, 3));
      idl = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 12)) : 0;
      trial(ra, rb, idl, 90);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule